// File: doc/BRIEF.md
# Leaky Bucket Activity Alarm Bank

This block keeps an activity alarm for each of a set of monitored clock inputs. A front end outside the block measures each input. Once per measurement interval it raises a common interval tick, and alongside it a per-input flag that says activity was missing in that interval. Each input owns a small integrator. The integrator counts up on intervals with missing activity and leaks away slowly over clean intervals. Its alarm uses two thresholds, so it does not chatter around a single level. The alarm vector feeds the no-activity alarm bits used when reference inputs are qualified.

The block holds four shared configuration profiles. Each profile sets an upper (set) threshold, a lower (clear) threshold, a bucket capacity and a leak rate. Every input picks one profile with its own 2-bit identifier, so inputs of similar character share one set of tuning values. Profiles are loaded through a one-cycle write port and come out of reset with usable defaults.

Top module: `act_alarm_bank`

## Requirements
- R1: After reset every alarm output is 0, and every bucket level and leak counter is 0.
- R2: After reset each of the four profiles holds upper 6, lower 4, capacity 8 and leak rate 1. With these defaults an input that misses on six consecutive ticks raises its alarm on the sixth tick and not before.
- R3: A tick with the missing flag set raises that input's level by one, but only while the level is below the profile capacity. Otherwise the level stays unchanged. Such a tick also restarts the input's clean-tick count at zero.
- R4: With leak rate r, the level drops by one after 2^r consecutive clean ticks, and the clean-tick count then restarts. A count already at or past the period after a rate change leaks on the next clean tick. The level never goes below zero.
- R5: The alarm rises on the tick where the new level is at or above the upper threshold.
- R6: Once raised, the alarm stays high until a tick leaves the level at or below the lower threshold while the level is also below the upper threshold.
- R7: If the lower threshold is programmed at or above the upper threshold, the alarm clears on the first tick that leaves the level below the upper threshold.
- R8: Input i uses profile k, where k is the unsigned value of bucket_id[2i+1:2i] (00 selects profile 0, through 11 selecting profile 3).
- R9: Without a tick, the missing flags have no effect: levels, counters and alarms hold.
- R10: A cycle with cfg_we high loads cfg_upper, cfg_lower, cfg_size and cfg_decay into the profile named by cfg_sel. The new values apply from the next tick onward.
- R11: All 14 inputs are processed in parallel and independently. The missing flag of one input never changes another input's alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Measurement interval strobe, one cycle |
| miss | input | 14 | Per-input activity-missing flag, sampled with tick |
| bucket_id | input | 28 | 2-bit profile select per input, input i at bits 2i+1:2i |
| cfg_we | input | 1 | Profile write strobe |
| cfg_sel | input | 2 | Profile to write |
| cfg_upper | input | 8 | Set threshold to write |
| cfg_lower | input | 8 | Clear threshold to write |
| cfg_size | input | 8 | Bucket capacity to write |
| cfg_decay | input | 2 | Leak rate to write |
| alarm | output | 14 | Registered per-input activity alarm |

## Verification
The level, the leak count and the alarm of each input are registered on the same rising edge that samples the tick, so the alarm for a tick is due one edge after the tick is driven. The bench drives the tick and flags on a falling edge and compares the whole alarm vector at the next falling edge against an arithmetic model that steps once per tick. A profile write takes one edge. The bench completes each write before the next tick, so the model applies new values from that tick on. During tick-free cycles the bench re-checks the alarm each cycle to confirm that nothing moved.

// File: rtl/act_alarm_pkg.sv
package act_alarm_pkg;
  localparam int LVL_W     = 8;
  localparam int DECAY_W   = 2;
  localparam int NUM_PROF  = 4;
  localparam int PROF_ID_W = $clog2(NUM_PROF);
  // widest leak period is 2^(2^DECAY_W - 1); counter holds period-1
  localparam int LEAK_W    = (1 << DECAY_W) - 1;

  typedef struct packed {
    logic [LVL_W-1:0]   upper;
    logic [LVL_W-1:0]   lower;
    logic [LVL_W-1:0]   size;
    logic [DECAY_W-1:0] decay;
  } prof_t;

  localparam prof_t PROF_DEFAULT = '{upper: LVL_W'(6), lower: LVL_W'(4),
                                     size: LVL_W'(8), decay: DECAY_W'(1)};
endpackage

// File: rtl/act_profile_file.sv
module act_profile_file
  import act_alarm_pkg::*;
#(
  parameter int N_PROF = NUM_PROF,
  localparam int SEL_W = $clog2(N_PROF)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [SEL_W-1:0]      wsel,
  input  prof_t                 wdata,
  output prof_t [N_PROF-1:0]    prof_o
);
  prof_t [N_PROF-1:0] prof_q;

  for (genvar k = 0; k < N_PROF; k++) begin : g_prof
    always_ff @(posedge clk) begin
      if (rst)                              prof_q[k] <= PROF_DEFAULT;
      else if (we && wsel == SEL_W'(k))     prof_q[k] <= wdata;
    end
  end

  assign prof_o = prof_q;

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    we |=> prof_q[$past(wsel)] == $past(wdata)); // R10
endmodule

// File: rtl/act_bucket_cell.sv
module act_bucket_cell
  import act_alarm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  miss,
  input  prof_t prof,
  output logic  alarm_o
);
  logic [LVL_W-1:0]  level_q, level_n;
  logic [LEAK_W-1:0] leak_q,  leak_n;
  logic              alarm_q, alarm_n;
  logic [LEAK_W:0]   leak_inc, leak_lim;

  assign leak_inc = {1'b0, leak_q} + (LEAK_W+1)'(1);
  assign leak_lim = (LEAK_W+1)'(1) << prof.decay;

  always_comb begin
    level_n = level_q;
    leak_n  = leak_q;
    if (miss) begin
      leak_n = '0;
      if (level_q < prof.size) level_n = level_q + LVL_W'(1);
    end else if (leak_inc >= leak_lim) begin
      leak_n = '0;
      if (level_q != '0) level_n = level_q - LVL_W'(1);
    end else begin
      leak_n = leak_inc[LEAK_W-1:0];
    end
    alarm_n = (level_n >= prof.upper) || (alarm_q && (level_n > prof.lower));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      leak_q  <= '0;
      alarm_q <= 1'b0;
    end else if (tick) begin
      level_q <= level_n;
      leak_q  <= leak_n;
      alarm_q <= alarm_n;
    end
  end

  assign alarm_o = alarm_q;

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level_q) && $stable(alarm_q)); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    tick |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + LVL_W'(1))
             || (level_q + LVL_W'(1) == $past(level_q))); // R3
  AST_RISE_AT_UPPER: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_q) |-> level_q >= $past(prof.upper)); // R5
  AST_FALL_AT_LOWER: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_q) |-> (level_q < $past(prof.upper)) &&
      ((level_q <= $past(prof.lower)) || ($past(prof.lower) >= $past(prof.upper)))); // R6
endmodule

// File: rtl/act_alarm_bank.sv
module act_alarm_bank
  import act_alarm_pkg::*;
#(
  parameter int N_IN = 14,
  localparam int ID_W = PROF_ID_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [N_IN-1:0]      miss,
  input  logic [N_IN*ID_W-1:0] bucket_id,
  input  logic                 cfg_we,
  input  logic [ID_W-1:0]      cfg_sel,
  input  logic [LVL_W-1:0]     cfg_upper,
  input  logic [LVL_W-1:0]     cfg_lower,
  input  logic [LVL_W-1:0]     cfg_size,
  input  logic [DECAY_W-1:0]   cfg_decay,
  output logic [N_IN-1:0]      alarm
);
  prof_t                 wdata;
  prof_t [NUM_PROF-1:0]  prof;

  assign wdata = '{upper: cfg_upper, lower: cfg_lower, size: cfg_size, decay: cfg_decay};

  act_profile_file #(.N_PROF(NUM_PROF)) u_prof (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wsel   (cfg_sel),
    .wdata  (wdata),
    .prof_o (prof)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    prof_t sel_prof;
    assign sel_prof = prof[bucket_id[i*ID_W +: ID_W]]; // R8

    act_bucket_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .miss    (miss[i]),
      .prof    (sel_prof),
      .alarm_o (alarm[i])
    );
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> alarm == '0); // R1
endmodule

// File: tb/act_alarm_bank_bench.sv
module act_alarm_bank_bench;
  localparam int N = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [N-1:0]  miss = '0;
  logic [2*N-1:0] bucket_id = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [7:0]    cfg_upper = '0, cfg_lower = '0, cfg_size = '0;
  logic [1:0]    cfg_decay = '0;
  logic [N-1:0]  alarm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int lvl [N];
  int lc  [N];
  bit al  [N];
  int id  [N];
  int up [4], lo [4], sz [4], dr [4];

  always #5 clk = ~clk;

  act_alarm_bank u_act_alarm_bank (
    .clk(clk), .rst(rst), .tick(tick), .miss(miss), .bucket_id(bucket_id),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_upper(cfg_upper),
    .cfg_lower(cfg_lower), .cfg_size(cfg_size), .cfg_decay(cfg_decay),
    .alarm(alarm)
  );

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = al[i];
    return v;
  endfunction

  task automatic check_vec(input logic [N-1:0] exp, input string tag);
    checks++;
    if (alarm !== exp) begin
      failures++;
      $display("FAIL %s alarm actual=%h expected=%h", tag, alarm, exp);
    end
  endtask

  // requirement arithmetic: step every input once for a tick
  task automatic model_step(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) begin
      int p = id[i];
      if (m[i]) begin
        lc[i] = 0;
        if (lvl[i] < sz[p]) lvl[i]++;
      end else if (lc[i] + 1 >= (1 << dr[p])) begin
        lc[i] = 0;
        if (lvl[i] > 0) lvl[i]--;
      end else lc[i]++;
      al[i] = (lvl[i] >= up[p]) || (al[i] && lvl[i] > lo[p]);
    end
  endtask

  task automatic do_tick(input logic [N-1:0] m, input string tag);
    @(negedge clk);
    tick = 1'b1; miss = m;
    @(negedge clk);
    tick = 1'b0; miss = '0;
    model_step(m);
    check_vec(model_vec(), tag);
  endtask

  task automatic write_prof(input int p, input int u, input int l, input int s, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(p);
    cfg_upper = 8'(u); cfg_lower = 8'(l); cfg_size = 8'(s); cfg_decay = 2'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    up[p] = u; lo[p] = l; sz[p] = s; dr[p] = d;
  endtask

  task automatic set_ids();
    for (int i = 0; i < N; i++) bucket_id[2*i +: 2] = 2'(id[i]);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin lvl[i] = 0; lc[i] = 0; al[i] = 0; id[i] = 0; end
    for (int p = 0; p < 4; p++) begin up[p] = 6; lo[p] = 4; sz[p] = 8; dr[p] = 1; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_vec('0, "R1 reset");

    // R2 / R5: defaults, six misses raise the alarm on the sixth tick
    for (int t = 0; t < 5; t++) do_tick('1, "R2 pre-threshold");
    check_vec('0, "R2 no alarm after five misses");
    do_tick('1, "R5 reach upper");
    check_vec('1, "R2 alarm on sixth miss");

    // R9: flags without tick change nothing
    miss = '1;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      check_vec(model_vec(), "R9 no tick");
    end
    miss = '0;

    // R6 / R4: level 6 leaks every 2 clean ticks, clears at 4
    for (int t = 0; t < 3; t++) do_tick('0, "R6 hold above lower");
    check_vec('1, "R6 still set at level 5");
    do_tick('0, "R6 clear at lower");
    check_vec('0, "R6 cleared at level 4");

    // R3: saturation at capacity 8, then slow drain
    for (int t = 0; t < 12; t++) do_tick('1, "R3 saturate");
    for (int t = 0; t < 20; t++) do_tick('0, "R4 drain to zero");

    // R11: only even inputs miss
    for (int t = 0; t < 7; t++) do_tick(14'h1555, "R11 independent");
    check_vec(14'h1555, "R11 only even inputs alarmed");
    for (int t = 0; t < 20; t++) do_tick('0, "R4 floor at zero");

    // R8 / R10 / R7: swept profiles, ids and miss densities
    for (int cs = 0; cs < 3; cs++) begin
      for (int p = 0; p < 4; p++) begin
        int u = 2 + (p * 3 + cs) % 7;
        int l = (p + cs * 2) % 6;
        int s = u + (p + cs) % 4;
        if (cs == 2 && p == 3) s = u - 1;
        write_prof(p, u, l, s, (p + cs) % 4);
      end
      for (int i = 0; i < N; i++) id[i] = (i + cs) % 4;
      set_ids();
      for (int dens = 1; dens < 8; dens += 2) begin
        for (int t = 0; t < 60; t++) begin
          logic [N-1:0] m;
          for (int i = 0; i < N; i++) m[i] = (($urandom % 8) < dens);
          do_tick(m, "R3/R4/R5/R6/R7/R8/R10 sweep");
        end
      end
    end

    // R7 directed: lower above upper clears as soon as below upper
    write_prof(1, 3, 7, 9, 0);
    for (int i = 0; i < N; i++) id[i] = 1;
    set_ids();
    for (int t = 0; t < 20; t++) do_tick('0, "R7 empty");
    for (int t = 0; t < 3; t++) do_tick('1, "R7 fill");
    check_vec('1, "R7 set at 3");
    do_tick('0, "R7 clear below upper");
    check_vec('0, "R7 cleared at 2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule